// File: doc/BRIEF.md
# Paged Memory Mapping Protection Unit

This block sits between a 16-bit word-addressed processor bus and a 1M-word physical memory. On each memory cycle it takes the upper four bits of the latched logical address, an address-state group select and the instruction/data qualifier, and picks one page descriptor. From that descriptor it drives an 8-bit physical page number, which picks one of 256 pages of 4K words. In the same step it checks the bus access key against the lock held in the descriptor, and checks the cycle type against the execute-protect and write-protect bits.

Every group select value owns two sets of sixteen descriptors, one for instruction fetches and one for data accesses. Software fills them through a single-entry load port. A tracker remembers the last physical page used. When a memory cycle lands on a different page, or is the first one after reset, the data-ready output drops for one clock to insert a wait state. I/O cycles pass through with no translation and no checks.

Top module: `paged_map_unit`

## Requirements
- R1: After reset, every descriptor maps logical page n (n = 0..15) of every group and both sets to physical page n, with lock 0 and both protect bits clear. After reset `prot_err_n` and `data_rdy` are 1 and `phys_page` is 0.
- R2: A memory cycle translates to the page field of the descriptor chosen by `grp_sel`, `is_data` (1 = data set, 0 = instruction set) and `log_addr[15:12]`. A load entry is packed as [7:0] physical page, [11:8] lock, [12] execute-protect, [13] write-protect.
- R3: A memory cycle whose `acc_key` is non-zero and differs from the descriptor lock drives `prot_err_n` low. A key of zero matches every lock.
- R4: An instruction fetch (`is_data` = 0) from a descriptor with execute-protect set drives `prot_err_n` low.
- R5: A data write (`is_data` = 1, `is_read` = 0) to a descriptor with write-protect set drives `prot_err_n` low. Reads, and instruction-set cycles, ignore write-protect.
- R6: A memory cycle whose physical page differs from the last one used, or the first memory cycle after reset, drives `data_rdy` low for exactly one clock.
- R7: A memory cycle on the same physical page as the last one keeps `data_rdy` high.
- R8: An I/O cycle (`is_mem` = 0) leaves `prot_err_n` high, `data_rdy` high and `phys_page` unchanged. It does not change the last-page tracker.
- R9: A cycle is taken on the first clock edge at which `addr_strobe` is seen low after having been high. `phys_page` and `prot_err_n` are registered at that edge and hold until the next such edge.
- R10: A load through `cfg_we` takes effect at its clock edge and is used by every cycle captured afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_strobe | input | 1 | Address strobe, active high; a cycle is taken on its falling transition |
| log_addr | input | 16 | Logical word address |
| grp_sel | input | 4 | Address-state group select |
| acc_key | input | 4 | Access key of the cycle |
| is_data | input | 1 | 1 = data access, 0 = instruction fetch |
| is_read | input | 1 | 1 = read, 0 = write |
| is_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cfg_we | input | 1 | Descriptor load enable |
| cfg_grp | input | 4 | Group of the descriptor to load |
| cfg_data_set | input | 1 | Set of the descriptor to load (1 = data) |
| cfg_idx | input | 4 | Logical page index of the descriptor to load |
| cfg_entry | input | 14 | Descriptor contents, packed as in R2 |
| phys_page | output | 8 | Physical page number |
| prot_err_n | output | 1 | Protection error, active low |
| data_rdy | output | 1 | Data ready, low for one clock on a page miss |

## Verification
Page number and error come from a single register stage. They are due one edge after the strobe is first seen low, so the bench samples them at the falling clock edge that follows. The one-clock wait is checked at that same falling edge and again one cycle later, where `data_rdy` must be back high and both other outputs unchanged. A descriptor load is driven a full clock before the strobe falls, so every access sees the descriptor that the model holds.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    parameter int ADDR_W = 16;
    parameter int GRP_W  = 4;
    parameter int KEY_W  = 4;
    parameter int PAGE_W = 8;
    parameter int IDX_W  = 4;

    localparam int SET_SIZE = 1 << IDX_W;
    localparam int ENTRIES  = (1 << GRP_W) * 2 * SET_SIZE;
    localparam int SEL_W    = GRP_W + 1 + IDX_W;

    typedef struct packed {
        logic              wprot;
        logic              xprot;
        logic [KEY_W-1:0]  lock;
        logic [PAGE_W-1:0] page;
    } page_desc_t;

    localparam int DESC_W = $bits(page_desc_t);
endpackage

// File: rtl/pmu_page_store.sv
module pmu_page_store
    import pmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] waddr,
    input  page_desc_t       wdata,
    input  logic [SEL_W-1:0] raddr,
    output page_desc_t       rdata
);
    page_desc_t tbl_d [ENTRIES];
    page_desc_t tbl_q [ENTRIES];

    always_comb begin
        tbl_d = tbl_q;
        if (we) tbl_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tbl_q[i].wprot <= 1'b0;
                tbl_q[i].xprot <= 1'b0;
                tbl_q[i].lock  <= '0;
                tbl_q[i].page  <= PAGE_W'(i % SET_SIZE);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rdata = tbl_q[raddr];

    // R10
    stable_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(we) && $stable(raddr)) |-> $stable(rdata));
endmodule

// File: rtl/pmu_access_check.sv
module pmu_access_check
    import pmu_pkg::*;
(
    input  page_desc_t       desc,
    input  logic [KEY_W-1:0] key,
    input  logic             is_data,
    input  logic             is_read,
    input  logic             is_mem,
    output logic             violation
);
    logic key_bad;
    logic exec_bad;
    logic write_bad;

    always_comb begin
        key_bad   = (key != '0) && (key != desc.lock);
        exec_bad  = !is_data && desc.xprot;
        write_bad = is_data && !is_read && desc.wprot;
        violation = is_mem && (key_bad || exec_bad || write_bad);
    end
endmodule

// File: rtl/pmu_miss_track.sv
module pmu_miss_track
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [PAGE_W-1:0] page,
    output logic              rdy
);
    typedef struct packed {
        logic              vld;
        logic [PAGE_W-1:0] last;
        logic              rdy;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rdy = 1'b1;
        if (req) begin
            s_d.rdy  = s_q.vld && (s_q.last == page);
            s_d.vld  = 1'b1;
            s_d.last = page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.vld  <= 1'b0;
            s_q.last <= '0;
            s_q.rdy  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdy = s_q.rdy;

    // R6
    one_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy |=> rdy);
endmodule

// File: rtl/paged_map_unit.sv
module paged_map_unit
    import pmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_strobe,
    input  logic [ADDR_W-1:0] log_addr,
    input  logic [GRP_W-1:0]  grp_sel,
    input  logic [KEY_W-1:0]  acc_key,
    input  logic              is_data,
    input  logic              is_read,
    input  logic              is_mem,
    input  logic              cfg_we,
    input  logic [GRP_W-1:0]  cfg_grp,
    input  logic              cfg_data_set,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [DESC_W-1:0] cfg_entry,
    output logic [PAGE_W-1:0] phys_page,
    output logic              prot_err_n,
    output logic              data_rdy
);
    typedef struct packed {
        logic              strb;
        logic [PAGE_W-1:0] page;
        logic              err_n;
    } top_t;

    top_t s_d, s_q;

    logic             cap;
    logic [SEL_W-1:0] rd_sel;
    logic [SEL_W-1:0] wr_sel;
    page_desc_t       rd_desc;
    logic             viol;

    assign cap    = s_q.strb && !addr_strobe;
    assign rd_sel = {grp_sel, is_data, log_addr[ADDR_W-1 -: IDX_W]};
    assign wr_sel = {cfg_grp, cfg_data_set, cfg_idx};

    pmu_page_store u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .waddr (wr_sel),
        .wdata (page_desc_t'(cfg_entry)),
        .raddr (rd_sel),
        .rdata (rd_desc)
    );

    pmu_access_check u_check (
        .desc      (rd_desc),
        .key       (acc_key),
        .is_data   (is_data),
        .is_read   (is_read),
        .is_mem    (is_mem),
        .violation (viol)
    );

    pmu_miss_track u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (cap && is_mem),
        .page  (rd_desc.page),
        .rdy   (data_rdy)
    );

    always_comb begin
        s_d      = s_q;
        s_d.strb = addr_strobe;
        if (cap) begin
            s_d.err_n = !viol;
            if (is_mem) s_d.page = rd_desc.page;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.strb  <= 1'b0;
            s_q.page  <= '0;
            s_q.err_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign phys_page  = s_q.page;
    assign prot_err_n = s_q.err_n;

    // R9
    hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(phys_page) && $stable(prot_err_n)));

    // R8
    io_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && !is_mem) |=> (prot_err_n && data_rdy && $stable(phys_page)));

    // R3
    master_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap && is_mem && acc_key == '0 && is_data && is_read) |=> prot_err_n);
endmodule

// File: tb/paged_map_unit_test.sv
module paged_map_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_strobe = 1'b0;
    logic [15:0] log_addr = '0;
    logic [3:0]  grp_sel = '0;
    logic [3:0]  acc_key = '0;
    logic        is_data = 1'b0;
    logic        is_read = 1'b1;
    logic        is_mem = 1'b1;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_grp = '0;
    logic        cfg_data_set = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [13:0] cfg_entry = '0;
    logic [7:0]  phys_page;
    logic        prot_err_n;
    logic        data_rdy;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [13:0] model [512];
    logic        last_vld = 1'b0;
    logic [7:0]  last_pg = '0;
    logic [7:0]  exp_pg = '0;

    paged_map_unit uut (.*);

    always #10 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int g, input int d, input int i, input logic [13:0] e);
        @(negedge clk);
        cfg_we = 1'b1; cfg_grp = 4'(g); cfg_data_set = d[0]; cfg_idx = 4'(i); cfg_entry = e;
        @(negedge clk);
        cfg_we = 1'b0;
        model[g*32 + d*16 + i] = e;
    endtask

    task automatic access(input int g, input int k, input int d, input int r, input int m, input int off);
        logic [13:0] e;
        logic        err;
        logic        miss;
        logic [15:0] a;
        int          i;
        i = (off >> 12) & 15;
        a = 16'(off);
        @(negedge clk);
        addr_strobe = 1'b1; grp_sel = 4'(g); acc_key = 4'(k);
        is_data = d[0]; is_read = r[0]; is_mem = m[0]; log_addr = a;
        @(negedge clk);
        addr_strobe = 1'b0;
        err = 1'b0; miss = 1'b0;
        if (m != 0) begin
            e = model[g*32 + d*16 + i];
            err = (k != 0 && 4'(k) != e[11:8]) || (d == 0 && e[12]) ||
                  (d == 1 && r == 0 && e[13]);
            miss = !last_vld || (e[7:0] != last_pg);
            last_vld = 1'b1; last_pg = e[7:0];
            exp_pg = e[7:0];
        end
        @(negedge clk);
        check(m != 0 ? "R2 page" : "R8 io page", 32'(phys_page), 32'(exp_pg));
        check(m == 0 ? "R8 io err" : (d == 0 ? "R4/R3 err" : "R5/R3 err"),
              32'(prot_err_n), 32'(!err));
        check(miss ? "R6 miss wait" : "R7 hit ready", 32'(data_rdy), 32'(!miss));
        @(negedge clk);
        check("R6 ready back", 32'(data_rdy), 32'd1);
        check("R9 page hold", 32'(phys_page), 32'(exp_pg));
        check("R9 err hold", 32'(prot_err_n), 32'(!err));
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 512; n++) model[n] = 14'(n % 16);
        repeat (3) @(negedge clk);
        check("R1 reset rdy", 32'(data_rdy), 32'd1);
        check("R1 reset err", 32'(prot_err_n), 32'd1);
        check("R1 reset page", 32'(phys_page), 32'd0);
        rst_n = 1'b1;
        // R1: identity map sweep, first access is a miss
        for (int g = 0; g < 16; g++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 16; i++)
                    access(g, 0, d, 1, 1, (i << 12) | (g * 7 + d));
        // R10 and R2: reprogram every descriptor
        for (int g = 0; g < 16; g++)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 16; i++)
                    load(g, d, i, {1'(i >> 1), 1'(i >> 2), 4'(g + i), 8'(g * 37 + d * 11 + i * 5)});
        // R3 R4 R5 R7: key, set and direction sweep
        for (int g = 0; g < 16; g += 5)
            for (int d = 0; d < 2; d++)
                for (int i = 0; i < 16; i++) begin
                    for (int r = 0; r < 2; r++)
                        for (int k = 0; k < 16; k++)
                            access(g, k, d, r, 1, (i << 12) | (k * 9 + r));
                    // R8: I/O cycle with bad key and write
                    access(g, 15 - (g + i) % 16, d, 0, 0, i << 12);
                end
        // R10: reload an entry right before using it
        load(3, 1, 9, {1'b1, 1'b0, 4'h6, 8'hA5});
        access(3, 6, 1, 0, 1, 16'h9123);
        access(3, 6, 1, 1, 1, 16'h9124);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule